// File: doc/BRIEF.md
# Cache Maintenance Sequencer

This block carries out maintenance on the directory of a four-way set-associative cache. The directory holds one valid bit and one dirty bit per line. Software reaches the block through a small control register and a push command. The register holds a lookup-enable bit, a start bit for clearing every line, and a policy bit. The policy bit decides whether a pushed line stays valid. A push names its line directly by set index and way, not by tag.

The tag/state array sits outside the block. The sequencer drives the array's index, way, read strobe and per-way write enables, and it gets the stored valid and dirty bits back one cycle after a read. Pushing a modified line starts a writeback request/acknowledge handshake before the line's state is changed. A parameter picks the line count: 512 lines in 128 sets, or 1024 lines in 256 sets. The lookup path, line data and the memory bus are handled elsewhere.

Top module: `cache_maint_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `ctrl_q` reads 0, `lookup_en` and `busy` are 0, and no directory write enable is raised. Reset leaves every stored directory entry as it was.
- R2: A control write taken while idle loads `ctrl_wdata` into `ctrl_q` one cycle later. Bit 0 is lookup enable and drives `lookup_en`. Bit 1 starts invalidate-all. Bit 2 is keep-on-push.
- R3: Writing bit 1 as 1 clears valid and dirty in all four ways of each set. It handles one set per cycle, in ascending order from set 0, and writes each set exactly once. `busy` stays high for exactly one cycle per set, and bit 1 of `ctrl_q` returns to 0 when the last set has been written.
- R4: A push first reads the named line (`dir_re` high for one cycle with the named set and way). If the line is valid and dirty, `wb_req` rises and stays high, with `dir_idx`/`dir_way` held, until `wb_ack` is sampled high. A single write to that way alone then clears the dirty bit.
- R5: With keep-on-push (bit 2) set, a pushed dirty line is written back and left valid with dirty cleared. A pushed clean line is left untouched, with no write at all.
- R6: With keep-on-push clear, pushing a clean valid line or an invalid line raises no `wb_req`. The line ends invalid and clean.
- R7: While `busy` is high, push commands and control writes are refused and change nothing. A push offered in the same cycle as a control write is refused.
- R8: The lookup-enable bit does not gate pushes or invalidate-all. Both run whether it is 0 or 1.
- R9: The `LINES` parameter sets the number of sets to `LINES`/4: 128 sets for 512 lines and 256 sets for 1024 lines. An invalidate-all walk lasts that many cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 3 | Control write data: bit0 enable, bit1 invalidate-all, bit2 keep-on-push |
| ctrl_q | output | 3 | Current control register value |
| lookup_en | output | 1 | Cache enabled for lookups |
| push_valid | input | 1 | Push command strobe |
| push_set | input | IDX_W | Set index of the line to push |
| push_way | input | 2 | Way of the line to push |
| busy | output | 1 | A walk or a push is in progress |
| dir_re | output | 1 | Directory read strobe |
| dir_idx | output | IDX_W | Directory set index |
| dir_way | output | 2 | Directory way for reads |
| dir_we | output | 4 | Per-way directory write enables |
| dir_wvalid | output | 1 | Valid bit written |
| dir_wdirty | output | 1 | Dirty bit written |
| dir_rvalid | input | 1 | Valid bit read, one cycle after `dir_re` |
| dir_rdirty | input | 1 | Dirty bit read, one cycle after `dir_re` |
| wb_req | output | 1 | Writeback request for a dirty pushed line |
| wb_ack | input | 1 | Writeback done |

## Verification
The embedded assertions check, on every cycle, the properties of the sequencing itself. The walk starts at set 0 and steps by one set per cycle, and it stops with the start bit cleared. The walk and a push never own the directory together. A pending writeback holds its line address. Each push write touches one way and writes the expected valid value. Nothing is accepted while busy, and nothing is written during reset. Only the bench's scenarios can show the end state of the array. Those scenarios check what reset, the walk and each kind of push leave in a model of the directory. They also check that refused commands leave `ctrl_q` and the read strobe unchanged, and that the walk length follows `LINES`.

// File: rtl/cmr_pkg.sv
`timescale 1ns/1ps
package cmr_pkg;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int CTRL_W = 3;

  typedef struct packed {
    logic keep_on_push; // bit 2
    logic inv_all;      // bit 1
    logic enable;       // bit 0
  } cmr_ctrl_t;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_LOOKUP,
    PS_DECIDE,
    PS_WBACK
  } cmr_push_st_e;

  function automatic logic [WAYS-1:0] cmr_way_dec(input logic [WAY_W-1:0] w);
    logic [WAYS-1:0] r;
    r    = '0;
    r[w] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/cmr_ctrl_reg.sv
`timescale 1ns/1ps
module cmr_ctrl_reg
  import cmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_acc,
  input  cmr_ctrl_t wdata,
  input  logic      walk_done,
  output cmr_ctrl_t q,
  output logic      walk_start
);
  cmr_ctrl_t q_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else if (wr_acc) begin
      q_r <= wdata;
    end else if (walk_done) begin
      q_r.inv_all <= 1'b0;
    end
  end

  assign q          = q_r;
  assign walk_start = wr_acc & wdata.inv_all;

  AST_INV_SELFCLR: assert property (@(posedge clk) disable iff (rst)
    walk_done |=> !q_r.inv_all); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (q_r == '0)); // R1
endmodule

// File: rtl/cmr_walker.sv
`timescale 1ns/1ps
module cmr_walker
  import cmr_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             active,
  output logic             done,
  output logic [IDX_W-1:0] idx,
  output logic [WAYS-1:0]  we
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SETS - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic [WAYS-1:0]  we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      we_q     <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      we_q     <= '1;
    end else if (active_q) begin
      if (idx_q == LAST) begin
        active_q <= 1'b0;
        we_q     <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign active = active_q;
  assign done   = active_q && (idx_q == LAST);
  assign idx    = idx_q;
  assign we     = we_q;

  AST_WALK_START: assert property (@(posedge clk) disable iff (rst)
    start |=> (active_q && (idx_q == '0) && (we_q == '1))); // R3
  AST_WALK_STEP: assert property (@(posedge clk) disable iff (rst)
    (active_q && !done) |=> (active_q && (idx_q == $past(idx_q) + 1'b1))); // R3
  AST_WALK_END: assert property (@(posedge clk) disable iff (rst)
    done |=> (!active_q && (we_q == '0))); // R3
endmodule

// File: rtl/cmr_push_seq.sv
`timescale 1ns/1ps
module cmr_push_seq
  import cmr_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] set_i,
  input  logic [WAY_W-1:0] way_i,
  input  logic             keep_i,
  input  logic             rvalid_i,
  input  logic             rdirty_i,
  input  logic             wb_ack_i,
  output logic             busy,
  output logic             re,
  output logic [IDX_W-1:0] idx,
  output logic [WAY_W-1:0] way,
  output logic [WAYS-1:0]  we,
  output logic             wvalid,
  output logic             wdirty,
  output logic             wb_req
);
  cmr_push_st_e     st_q;
  logic             re_q;
  logic [IDX_W-1:0] idx_q;
  logic [WAY_W-1:0] way_q;
  logic [WAYS-1:0]  we_q;
  logic             wvalid_q;
  logic             wdirty_q;
  logic             wb_req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= PS_IDLE;
      re_q     <= 1'b0;
      idx_q    <= '0;
      way_q    <= '0;
      we_q     <= '0;
      wvalid_q <= 1'b0;
      wdirty_q <= 1'b0;
      wb_req_q <= 1'b0;
    end else begin
      we_q <= '0;
      unique case (st_q)
        PS_IDLE: begin
          if (start) begin
            idx_q <= set_i;
            way_q <= way_i;
            re_q  <= 1'b1;
            st_q  <= PS_LOOKUP;
          end
        end
        PS_LOOKUP: begin
          re_q <= 1'b0;
          st_q <= PS_DECIDE;
        end
        PS_DECIDE: begin
          if (rvalid_i && rdirty_i) begin
            wb_req_q <= 1'b1;
            st_q     <= PS_WBACK;
          end else begin
            if (!keep_i) begin
              we_q     <= cmr_way_dec(way_q);
              wvalid_q <= 1'b0;
              wdirty_q <= 1'b0;
            end
            st_q <= PS_IDLE;
          end
        end
        PS_WBACK: begin
          if (wb_ack_i) begin
            wb_req_q <= 1'b0;
            we_q     <= cmr_way_dec(way_q);
            wvalid_q <= keep_i;
            wdirty_q <= 1'b0;
            st_q     <= PS_IDLE;
          end
        end
        default: st_q <= PS_IDLE;
      endcase
    end
  end

  assign busy   = (st_q != PS_IDLE);
  assign re     = re_q;
  assign idx    = idx_q;
  assign way    = way_q;
  assign we     = we_q;
  assign wvalid = wvalid_q;
  assign wdirty = wdirty_q;
  assign wb_req = wb_req_q;

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wb_req_q && !wb_ack_i) |=> (wb_req_q && $stable(idx_q) && $stable(way_q))); // R4
  AST_PUSH_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we_q)); // R4
  AST_CLEAN_NO_WB: assert property (@(posedge clk) disable iff (rst)
    ((st_q == PS_DECIDE) && !(rvalid_i && rdirty_i)) |=> !wb_req_q); // R6
  AST_PUSH_WR_VALUE: assert property (@(posedge clk) disable iff (rst)
    (|we_q) |-> ((wvalid_q == keep_i) && !wdirty_q)); // R5
endmodule

// File: rtl/cache_maint_ctrl.sv
`timescale 1ns/1ps
module cache_maint_ctrl
  import cmr_pkg::*;
#(
  parameter  int LINES = 512,
  localparam int SETS  = LINES / WAYS,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              lookup_en,
  input  logic              push_valid,
  input  logic [IDX_W-1:0]  push_set,
  input  logic [WAY_W-1:0]  push_way,
  output logic              busy,
  output logic              dir_re,
  output logic [IDX_W-1:0]  dir_idx,
  output logic [WAY_W-1:0]  dir_way,
  output logic [WAYS-1:0]   dir_we,
  output logic              dir_wvalid,
  output logic              dir_wdirty,
  input  logic              dir_rvalid,
  input  logic              dir_rdirty,
  output logic              wb_req,
  input  logic              wb_ack
);
  cmr_ctrl_t        creg;
  logic             ctrl_acc;
  logic             push_acc;
  logic             walk_start;
  logic             walk_active;
  logic             walk_done;
  logic [IDX_W-1:0] walk_idx;
  logic [WAYS-1:0]  walk_we;
  logic             push_busy;
  logic [IDX_W-1:0] push_idx;
  logic [WAYS-1:0]  push_we;
  logic             push_wvalid;
  logic             push_wdirty;

  // Control writes win over a push offered in the same cycle.
  assign ctrl_acc = ctrl_wr & ~busy;
  assign push_acc = push_valid & ~busy & ~ctrl_wr;

  cmr_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_acc     (ctrl_acc),
    .wdata      (cmr_ctrl_t'(ctrl_wdata)),
    .walk_done  (walk_done),
    .q          (creg),
    .walk_start (walk_start)
  );

  cmr_walker #(.SETS(SETS), .IDX_W(IDX_W)) u_walk (
    .clk    (clk),
    .rst    (rst),
    .start  (walk_start),
    .active (walk_active),
    .done   (walk_done),
    .idx    (walk_idx),
    .we     (walk_we)
  );

  cmr_push_seq #(.IDX_W(IDX_W)) u_push (
    .clk      (clk),
    .rst      (rst),
    .start    (push_acc),
    .set_i    (push_set),
    .way_i    (push_way),
    .keep_i   (creg.keep_on_push),
    .rvalid_i (dir_rvalid),
    .rdirty_i (dir_rdirty),
    .wb_ack_i (wb_ack),
    .busy     (push_busy),
    .re       (dir_re),
    .idx      (push_idx),
    .way      (dir_way),
    .we       (push_we),
    .wvalid   (push_wvalid),
    .wdirty   (push_wdirty),
    .wb_req   (wb_req)
  );

  // Only one sequencer owns the directory at a time, so the merge is an OR.
  for (genvar g = 0; g < WAYS; g++) begin : g_we
    assign dir_we[g] = walk_we[g] | push_we[g];
  end

  assign dir_idx    = walk_active ? walk_idx : push_idx;
  assign dir_wvalid = (|push_we) & push_wvalid;
  assign dir_wdirty = (|push_we) & push_wdirty;
  assign busy       = walk_active | push_busy;
  assign ctrl_q     = creg;
  assign lookup_en  = creg.enable;

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    !(walk_active && push_busy)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> ((dir_we == '0) && !wb_req && !busy)); // R1
  AST_REFUSE_CTRL: assert property (@(posedge clk) disable iff (rst)
    (busy && ctrl_wr && !walk_done) |=> (ctrl_q == $past(ctrl_q))); // R7
  AST_REFUSE_PUSH: assert property (@(posedge clk) disable iff (rst)
    busy |=> !dir_re); // R7
endmodule

// File: tb/test_cache_maint_ctrl.sv
`timescale 1ns/1ps
module test_cache_maint_ctrl;
  localparam int SETS_A = 128;
  localparam int IW_A   = 7;
  localparam int SETS_B = 256;
  localparam int IW_B   = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst = 1'b1;
  logic            ctrl_wr = 1'b0;
  logic [2:0]      ctrl_wdata = '0;
  logic [2:0]      ctrl_q;
  logic            lookup_en;
  logic            push_valid = 1'b0;
  logic [IW_A-1:0] push_set = '0;
  logic [1:0]      push_way = '0;
  logic            busy;
  logic            dir_re;
  logic [IW_A-1:0] dir_idx;
  logic [1:0]      dir_way;
  logic [3:0]      dir_we;
  logic            dir_wvalid, dir_wdirty;
  logic            dir_rvalid = 1'b0, dir_rdirty = 1'b0;
  logic            wb_req;
  logic            wb_ack = 1'b0;

  logic            ctrl_wr_b = 1'b0;
  logic [2:0]      ctrl_wdata_b = '0;
  logic [2:0]      ctrl_q_b;
  logic            lookup_en_b, busy_b, dir_re_b, dir_wvalid_b, dir_wdirty_b, wb_req_b;
  logic [IW_B-1:0] dir_idx_b;
  logic [1:0]      dir_way_b;
  logic [3:0]      dir_we_b;

  cache_maint_ctrl #(.LINES(512)) i_cache_maint_ctrl (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
    .lookup_en(lookup_en), .push_valid(push_valid), .push_set(push_set), .push_way(push_way),
    .busy(busy), .dir_re(dir_re), .dir_idx(dir_idx), .dir_way(dir_way), .dir_we(dir_we),
    .dir_wvalid(dir_wvalid), .dir_wdirty(dir_wdirty), .dir_rvalid(dir_rvalid),
    .dir_rdirty(dir_rdirty), .wb_req(wb_req), .wb_ack(wb_ack)
  );

  cache_maint_ctrl #(.LINES(1024)) i_cache_maint_ctrl_1k (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr_b), .ctrl_wdata(ctrl_wdata_b), .ctrl_q(ctrl_q_b),
    .lookup_en(lookup_en_b), .push_valid(1'b0), .push_set('0), .push_way(2'd0),
    .busy(busy_b), .dir_re(dir_re_b), .dir_idx(dir_idx_b), .dir_way(dir_way_b), .dir_we(dir_we_b),
    .dir_wvalid(dir_wvalid_b), .dir_wdirty(dir_wdirty_b), .dir_rvalid(1'b0),
    .dir_rdirty(1'b0), .wb_req(wb_req_b), .wb_ack(1'b0)
  );

  // Directory model: synchronous read, per-way write, preload and clear port.
  logic mv [SETS_A][4];
  logic md [SETS_A][4];
  logic pl_en = 1'b0, pl_clr = 1'b0, pl_v = 1'b0, pl_d = 1'b0;
  logic [IW_A-1:0] pl_set = '0;
  logic [1:0] pl_way = '0;

  always @(posedge clk) begin
    if (pl_clr) begin
      for (int s = 0; s < SETS_A; s++)
        for (int w = 0; w < 4; w++) begin
          mv[s][w] <= 1'b0;
          md[s][w] <= 1'b0;
        end
    end else begin
      if (dir_re) begin
        dir_rvalid <= mv[dir_idx][dir_way];
        dir_rdirty <= md[dir_idx][dir_way];
      end
      for (int w = 0; w < 4; w++)
        if (dir_we[w]) begin
          mv[dir_idx][w] <= dir_wvalid;
          md[dir_idx][w] <= dir_wdirty;
        end
      if (pl_en) begin
        mv[pl_set][pl_way] <= pl_v;
        md[pl_set][pl_way] <= pl_d;
      end
    end
  end

  // Activity monitor, sampled mid-cycle.
  int wr_cnt = 0, re_cnt = 0, busy_cnt = 0, walk_bad = 0, walk_next = 0;
  int wr_b = 0, busy_bc = 0;
  logic [3:0] last_we = '0;
  logic last_wv = 1'b0, last_wd = 1'b0;
  always @(negedge clk) begin
    if (|dir_we) begin
      wr_cnt++;
      last_we = dir_we;
      last_wv = dir_wvalid;
      last_wd = dir_wdirty;
    end
    if (dir_re) re_cnt++;
    if (busy) busy_cnt++;
    if (dir_we == 4'hF) begin
      if (dir_idx != IW_A'(walk_next) || dir_wvalid || dir_wdirty) walk_bad++;
      walk_next = (walk_next + 1) % SETS_A;
    end
    if (|dir_we_b) wr_b++;
    if (busy_b) busy_bc++;
  end

  int checks = 0, errors = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic preload(input int s, input int w, input bit v, input bit d);
    @(negedge clk);
    pl_set = IW_A'(s); pl_way = 2'(w); pl_v = v; pl_d = d; pl_en = 1'b1;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic clear_model();
    @(negedge clk); pl_clr = 1'b1;
    @(negedge clk); pl_clr = 1'b0;
  endtask

  task automatic ctrl_write(input logic [2:0] d);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  // Push one line; acknowledge writeback after ack_after cycles of request.
  task automatic do_push(input string req, input int s, input int w, input int ack_after,
                         output int wb_seen, output int hold_bad);
    int guard;
    wb_seen = 0; hold_bad = 0; guard = 0;
    @(negedge clk);
    push_valid = 1'b1; push_set = IW_A'(s); push_way = 2'(w);
    @(negedge clk);
    push_valid = 1'b0;
    chk(req, "lookup read strobe", int'(dir_re), 1);
    chk(req, "lookup index", int'(dir_idx), s);
    while (busy && guard < 200) begin
      wb_ack = 1'b0;
      if (wb_req) begin
        wb_seen++;
        if (dir_idx != IW_A'(s) || dir_way != 2'(w)) hold_bad++;
        if (wb_seen == ack_after) wb_ack = 1'b1;
      end
      @(negedge clk);
      guard++;
    end
    wb_ack = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    int w0;
    rst = 1'b1;
    preload(3, 1, 1'b1, 1'b1);
    preload(SETS_A - 1, 3, 1'b1, 1'b0);
    w0 = wr_cnt;
    ctrl_write(3'b011);
    repeat (3) @(negedge clk);
    chk("R1", "writes during reset", wr_cnt - w0, 0);
    chk("R1", "ctrl_q in reset", int'(ctrl_q), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "ctrl_q after reset", int'(ctrl_q), 0);
    chk("R1", "lookup_en after reset", int'(lookup_en), 0);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "entry 3/1 valid kept", int'(mv[3][1]), 1);
    chk("R1", "entry 3/1 dirty kept", int'(md[3][1]), 1);
    chk("R1", "entry last/3 valid kept", int'(mv[SETS_A-1][3]), 1);
  endtask

  task automatic t_ctrl();
    ctrl_write(3'b001);
    chk("R2", "ctrl_q after enable", int'(ctrl_q), 1);
    chk("R2", "lookup_en set", int'(lookup_en), 1);
    ctrl_write(3'b100);
    chk("R2", "ctrl_q after keep", int'(ctrl_q), 4);
    chk("R2", "lookup_en cleared", int'(lookup_en), 0);
    ctrl_write(3'b000);
  endtask

  task automatic t_push_dirty(input bit en);
    int seen, hb, w0;
    ctrl_write({2'b00, en});
    preload(10, 2, 1'b1, 1'b1);
    preload(10, 1, 1'b1, 1'b1);
    w0 = wr_cnt;
    do_push("R4", 10, 2, 3, seen, hb);
    chk("R4", "wb_req cycles before ack", seen, 3);
    chk("R4", "address hold during wb", hb, 0);
    chk("R4", "write count", wr_cnt - w0, 1);
    chk("R4", "write way enable", int'(last_we), 4);
    chk("R4", "pushed line valid", int'(mv[10][2]), 0);
    chk("R4", "pushed line dirty", int'(md[10][2]), 0);
    chk("R4", "neighbour way untouched", int'(mv[10][1] & md[10][1]), 1);
    chk("R8", "push works with enable", int'(lookup_en), int'(en));
  endtask

  task automatic t_push_keep();
    int seen, hb, w0;
    ctrl_write(3'b100);
    preload(20, 0, 1'b1, 1'b1);
    do_push("R5", 20, 0, 1, seen, hb);
    chk("R5", "dirty keep wb", seen, 1);
    chk("R5", "dirty keep valid", int'(mv[20][0]), 1);
    chk("R5", "dirty keep dirty", int'(md[20][0]), 0);
    preload(21, 3, 1'b1, 1'b0);
    w0 = wr_cnt;
    do_push("R5", 21, 3, 1, seen, hb);
    chk("R5", "clean keep wb", seen, 0);
    chk("R5", "clean keep writes", wr_cnt - w0, 0);
    chk("R5", "clean keep valid", int'(mv[21][3]), 1);
    ctrl_write(3'b000);
  endtask

  task automatic t_push_clean();
    int seen, hb, w0;
    preload(30, 1, 1'b1, 1'b0);
    do_push("R6", 30, 1, 1, seen, hb);
    chk("R6", "clean wb", seen, 0);
    chk("R6", "clean invalidated", int'(mv[30][1]), 0);
    w0 = wr_cnt;
    do_push("R6", 31, 2, 1, seen, hb);
    chk("R6", "invalid wb", seen, 0);
    chk("R6", "invalid writes", wr_cnt - w0, 1);
    chk("R6", "invalid stays invalid", int'(mv[31][2] | md[31][2]), 0);
  endtask

  task automatic t_walk();
    int b0, w0, k0, left, guard;
    preload(0, 0, 1'b1, 1'b1);
    preload(64, 3, 1'b1, 1'b0);
    preload(SETS_A - 1, 2, 1'b1, 1'b1);
    b0 = busy_cnt; w0 = wr_cnt; k0 = walk_bad; guard = 0;
    ctrl_write(3'b010);
    chk("R3", "busy at walk start", int'(busy), 1);
    chk("R3", "start bit visible", int'(ctrl_q), 2);
    chk("R8", "walk runs with lookup disabled", int'(lookup_en), 0);
    while (busy && guard < 1000) begin @(negedge clk); guard++; end
    chk("R3", "start bit self-cleared", int'(ctrl_q), 0);
    repeat (2) @(posedge clk);
    chk("R3", "busy cycles", busy_cnt - b0, SETS_A);
    chk("R9", "walk length 512 lines", wr_cnt - w0, SETS_A);
    chk("R3", "walk order and values", walk_bad - k0, 0);
    left = 0;
    for (int s = 0; s < SETS_A; s++)
      for (int w = 0; w < 4; w++) left += int'(mv[s][w]) + int'(md[s][w]);
    chk("R3", "entries left set", left, 0);
  endtask

  task automatic t_refuse();
    int r0, guard;
    r0 = re_cnt; guard = 0;
    ctrl_write(3'b011);
    @(negedge clk);
    push_valid = 1'b1; push_set = IW_A'(5); ctrl_wr = 1'b1; ctrl_wdata = 3'b100;
    repeat (3) @(negedge clk);
    push_valid = 1'b0; ctrl_wr = 1'b0;
    while (busy && guard < 1000) begin @(negedge clk); guard++; end
    @(posedge clk);
    chk("R7", "push refused while busy", re_cnt - r0, 0);
    chk("R7", "ctrl write refused while busy", int'(ctrl_q), 1);
    chk("R8", "walk with lookup enabled", int'(lookup_en), 1);
    r0 = re_cnt;
    @(negedge clk);
    push_valid = 1'b1; ctrl_wr = 1'b1; ctrl_wdata = 3'b000;
    @(negedge clk);
    push_valid = 1'b0; ctrl_wr = 1'b0;
    repeat (4) @(posedge clk);
    chk("R7", "same-cycle push refused", re_cnt - r0, 0);
    chk("R7", "same-cycle ctrl accepted", int'(ctrl_q), 0);
  endtask

  task automatic t_big();
    int b0, w0, guard;
    b0 = busy_bc; w0 = wr_b; guard = 0;
    @(negedge clk); ctrl_wr_b = 1'b1; ctrl_wdata_b = 3'b010;
    @(negedge clk); ctrl_wr_b = 1'b0;
    while (busy_b && guard < 2000) begin @(negedge clk); guard++; end
    repeat (2) @(posedge clk);
    chk("R9", "walk length 1024 lines", busy_bc - b0, SETS_B);
    chk("R9", "write count 1024 lines", wr_b - w0, SETS_B);
    chk("R9", "1024 start bit cleared", int'(ctrl_q_b), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_model();
    t_reset();
    t_ctrl();
    t_push_dirty(1'b0);
    t_push_dirty(1'b1);
    t_push_keep();
    t_push_clean();
    t_walk();
    t_refuse();
    t_big();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule